// File: doc/BRIEF.md
# Branch and Call Next-PC Unit

This block works out the address of the next instruction for a 32-bit RISC core. Each cycle in which `instValid` is high, it takes the current program counter, the instruction word and the values of the two source registers that the instruction names. It then registers the next program counter together with a set of control-flow flags. These flags are: a taken indication, a write request that puts the return address into the fixed link register, a flag for a misaligned indirect target, and one-cycle pulses that mark a plain return, an exception return and a breakpoint return.

Offsets are counted in instruction words. Conditional branches carry a signed 16-bit field in bits 15:0. Immediate jumps and calls carry a signed 26-bit field in bits 25:0. Indirect jumps and calls take their target from the first source register. A register jump through register 29, 30 or 31 is a return. The exception and breakpoint return pulses let status logic outside the block restore its enable state.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rstN` is low, `nextPc` equals RESET_PC (default 0), and `taken`, `linkWe`, `misaligned`, `subRet`, `excRet` and `brkRet` are all 0.
- R2: For opcode bits 31:26 equal to 17 (equal), 23 (not equal), 18 (signed greater), 19 (signed greater or equal), 21 (unsigned greater) or 20 (unsigned greater or equal), the block compares `regA` (the register in bits 25:21) with `regB` (the register in bits 20:16). If the condition holds, `nextPc` = `curPc` + (sign-extended bits 15:0 shifted left by 2) and `taken` = 1.
- R3: Opcodes 18 and 19 compare `regA` and `regB` as two's-complement values. Opcodes 20 and 21 compare them as unsigned values.
- R4: A conditional branch whose condition is false, or any opcode other than 17 to 21, 23, 48, 54, 56 and 62, gives `nextPc` = `curPc` + 4 and `taken` = 0.
- R5: Opcodes 56 (jump) and 62 (call) give `nextPc` = `curPc` + (sign-extended bits 25:0 shifted left by 2), with `taken` = 1.
- R6: Opcodes 48 (register jump) and 54 (register call) give `nextPc` = `regA`, with `taken` = 1.
- R7: Opcodes 54 and 62 assert `linkWe` with `linkData` = `curPc` + 4. `linkAddr` is always 29. No other opcode asserts `linkWe`.
- R8: Opcode 48 with bits 25:21 equal to 29, 30 or 31 raises `subRet`, `excRet` or `brkRet` respectively, for one cycle. At most one of these three is high at any time, and opcode 54 raises none of them.
- R9: For opcodes 48 and 54, `misaligned` is 1 exactly when bits 1:0 of `regA` are non-zero. For every other opcode it is 0.
- R10: In a cycle with `instValid` low, `nextPc` keeps its value, and `taken`, `linkWe`, `misaligned` and the three return pulses go to 0.
- R11: All outputs change at the rising clock edge that samples `instValid` high, and they reflect the inputs of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | Instruction inputs are valid this cycle |
| curPc | input | 32 | Address of the instruction |
| instWord | input | 32 | Instruction word |
| regA | input | 32 | Value of the register named by bits 25:21 |
| regB | input | 32 | Value of the register named by bits 20:16 |
| nextPc | output | 32 | Registered next program counter |
| taken | output | 1 | Control transfer taken |
| linkWe | output | 1 | Write request for the link register |
| linkAddr | output | 5 | Index of the link register (29) |
| linkData | output | 32 | Return address to write |
| misaligned | output | 1 | Indirect target with bits 1:0 non-zero |
| subRet | output | 1 | Pulse: return through register 29 |
| excRet | output | 1 | Pulse: exception return through register 30 |
| brkRet | output | 1 | Pulse: breakpoint return through register 31 |

## Verification
A wrong target select or a wrong comparator decode shows up as a bad `nextPc` or `taken` at the clock edge right after the instruction is presented. There is no internal state that could hide it for longer. A flag register that does not clear shows up as a pulse that lasts into the following idle cycle. Vectors with the same operands under signed and unsigned opcodes, negative offsets at both field widths, and returns through each of the three special registers expose a wrong sign extension, a swapped comparison or a wrong alias index within one cycle.

// File: rtl/pc_branch_pkg.sv
package pc_branch_pkg;
  localparam int XLEN       = 32;
  localparam int OP_W       = 6;
  localparam int RIDX_W     = 5;
  localparam int OFF_SHORT  = 16;
  localparam int OFF_LONG   = 26;
  localparam int INSTR_BYTES = 4;

  localparam logic [OP_W-1:0] OP_BR_EQ   = 6'd17;
  localparam logic [OP_W-1:0] OP_BR_SGT  = 6'd18;
  localparam logic [OP_W-1:0] OP_BR_SGE  = 6'd19;
  localparam logic [OP_W-1:0] OP_BR_UGE  = 6'd20;
  localparam logic [OP_W-1:0] OP_BR_UGT  = 6'd21;
  localparam logic [OP_W-1:0] OP_BR_NE   = 6'd23;
  localparam logic [OP_W-1:0] OP_JMP_REG = 6'd48;
  localparam logic [OP_W-1:0] OP_CALL_REG = 6'd54;
  localparam logic [OP_W-1:0] OP_JMP_IMM = 6'd56;
  localparam logic [OP_W-1:0] OP_CALL_IMM = 6'd62;

  localparam logic [RIDX_W-1:0] LINK_REG = 5'd29;
  localparam logic [RIDX_W-1:0] EXC_REG  = 5'd30;
  localparam logic [RIDX_W-1:0] BRK_REG  = 5'd31;

  typedef enum logic [1:0] {
    TGT_SEQ   = 2'd0,
    TGT_SHORT = 2'd1,
    TGT_LONG  = 2'd2,
    TGT_REG   = 2'd3
  } tgtSelE;

  typedef struct packed {
    tgtSelE tgtSel;
    logic   take;
    logic   link;
    logic   chkAlign;
    logic   subRet;
    logic   excRet;
    logic   brkRet;
  } pcStrobeT;
endpackage

// File: rtl/pc_branch_ctrl.sv
module pc_branch_ctrl
  import pc_branch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opcode,
  input  logic [RIDX_W-1:0] srcIdx,
  input  logic              cmpEq,
  input  logic              cmpSgt,
  input  logic              cmpUgt,
  output pcStrobeT          strobe
);
  logic condHit;
  logic isCond;

  always_comb begin
    isCond  = 1'b1;
    condHit = 1'b0;
    case (opcode)
      OP_BR_EQ:  condHit = cmpEq;
      OP_BR_NE:  condHit = !cmpEq;
      OP_BR_SGT: condHit = cmpSgt;
      OP_BR_SGE: condHit = cmpSgt | cmpEq;
      OP_BR_UGT: condHit = cmpUgt;
      OP_BR_UGE: condHit = cmpUgt | cmpEq;
      default:   isCond  = 1'b0;
    endcase
  end

  always_comb begin
    strobe = '0;
    strobe.tgtSel = TGT_SEQ;
    if (isCond) begin
      strobe.take   = condHit;
      strobe.tgtSel = condHit ? TGT_SHORT : TGT_SEQ;
    end else begin
      case (opcode)
        OP_JMP_IMM: begin
          strobe.take   = 1'b1;
          strobe.tgtSel = TGT_LONG;
        end
        OP_CALL_IMM: begin
          strobe.take   = 1'b1;
          strobe.link   = 1'b1;
          strobe.tgtSel = TGT_LONG;
        end
        OP_JMP_REG: begin
          strobe.take     = 1'b1;
          strobe.chkAlign = 1'b1;
          strobe.tgtSel   = TGT_REG;
          strobe.subRet   = (srcIdx == LINK_REG);
          strobe.excRet   = (srcIdx == EXC_REG);
          strobe.brkRet   = (srcIdx == BRK_REG);
        end
        OP_CALL_REG: begin
          strobe.take     = 1'b1;
          strobe.link     = 1'b1;
          strobe.chkAlign = 1'b1;
          strobe.tgtSel   = TGT_REG;
        end
        default: ;
      endcase
    end
  end

  AST_LINK_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.link |-> strobe.take); // R7
  AST_RET_NOT_ON_CALL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.link |-> !(strobe.subRet | strobe.excRet | strobe.brkRet)); // R8
  AST_SEQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tgtSel == TGT_SEQ) |-> !strobe.take); // R4
endmodule

// File: rtl/pc_branch_dp.sv
module pc_branch_dp
  import pc_branch_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic [XLEN-1:0]     curPc,
  input  logic [OFF_LONG-1:0] offField,
  input  logic [XLEN-1:0]     regA,
  input  logic [XLEN-1:0]     regB,
  input  pcStrobeT            strobe,
  output logic                cmpEq,
  output logic                cmpSgt,
  output logic                cmpUgt,
  output logic [XLEN-1:0]     nextPc,
  output logic                taken,
  output logic                linkWe,
  output logic [XLEN-1:0]     linkData,
  output logic                misaligned,
  output logic                subRet,
  output logic                excRet,
  output logic                brkRet
);
  localparam int WORD_SHIFT = $clog2(INSTR_BYTES);

  logic [XLEN-1:0] seqPc, shortTgt, longTgt, tgtPc;
  logic [XLEN-1:0] shortOff, longOff;

  assign cmpEq  = (regA == regB);
  assign cmpSgt = ($signed(regA) > $signed(regB));
  assign cmpUgt = (regA > regB);

  assign shortOff = XLEN'($signed(offField[OFF_SHORT-1:0])) << WORD_SHIFT;
  assign longOff  = XLEN'($signed(offField)) << WORD_SHIFT;
  assign seqPc    = curPc + XLEN'(INSTR_BYTES);
  assign shortTgt = curPc + shortOff;
  assign longTgt  = curPc + longOff;

  always_comb begin
    case (strobe.tgtSel)
      TGT_SHORT: tgtPc = shortTgt;
      TGT_LONG:  tgtPc = longTgt;
      TGT_REG:   tgtPc = regA;
      default:   tgtPc = seqPc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPc     <= RESET_PC;
      taken      <= 1'b0;
      linkWe     <= 1'b0;
      linkData   <= '0;
      misaligned <= 1'b0;
      subRet     <= 1'b0;
      excRet     <= 1'b0;
      brkRet     <= 1'b0;
    end else if (instValid) begin
      nextPc     <= tgtPc;
      taken      <= strobe.take;
      linkWe     <= strobe.link;
      linkData   <= seqPc;
      misaligned <= strobe.chkAlign && (regA[WORD_SHIFT-1:0] != '0);
      subRet     <= strobe.subRet;
      excRet     <= strobe.excRet;
      brkRet     <= strobe.brkRet;
    end else begin
      taken      <= 1'b0;
      linkWe     <= 1'b0;
      misaligned <= 1'b0;
      subRet     <= 1'b0;
      excRet     <= 1'b0;
      brkRet     <= 1'b0;
    end
  end

  AST_UNTAKEN_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    ($past(instValid) && !taken) |-> nextPc == $past(curPc) + XLEN'(INSTR_BYTES)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(instValid) |-> ($stable(nextPc) && !taken && !linkWe)); // R10
  AST_RET_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({subRet, excRet, brkRet})); // R8
  AST_MISALIGN_TGT: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (taken && nextPc[WORD_SHIFT-1:0] != '0)); // R9
  AST_LINK_RETADDR: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> linkData == $past(curPc) + XLEN'(INSTR_BYTES)); // R7
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pc_branch_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [31:0] curPc,
  input  logic [31:0] instWord,
  input  logic [31:0] regA,
  input  logic [31:0] regB,
  output logic [31:0] nextPc,
  output logic        taken,
  output logic        linkWe,
  output logic [4:0]  linkAddr,
  output logic [31:0] linkData,
  output logic        misaligned,
  output logic        subRet,
  output logic        excRet,
  output logic        brkRet
);
  pcStrobeT strobe;
  logic cmpEq, cmpSgt, cmpUgt;

  assign linkAddr = LINK_REG;

  pc_branch_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (instWord[XLEN-1 -: OP_W]),
    .srcIdx (instWord[XLEN-OP_W-1 -: RIDX_W]),
    .cmpEq  (cmpEq),
    .cmpSgt (cmpSgt),
    .cmpUgt (cmpUgt),
    .strobe (strobe)
  );

  pc_branch_dp #(.RESET_PC(RESET_PC)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .curPc      (curPc),
    .offField   (instWord[OFF_LONG-1:0]),
    .regA       (regA),
    .regB       (regB),
    .strobe     (strobe),
    .cmpEq      (cmpEq),
    .cmpSgt     (cmpSgt),
    .cmpUgt     (cmpUgt),
    .nextPc     (nextPc),
    .taken      (taken),
    .linkWe     (linkWe),
    .linkData   (linkData),
    .misaligned (misaligned),
    .subRet     (subRet),
    .excRet     (excRet),
    .brkRet     (brkRet)
  );
endmodule

// File: tb/pc_branch_unit_bench.sv
module pc_branch_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [31:0] curPc = '0, instWord = '0, regA = '0, regB = '0;
  logic [31:0] nextPc, linkData;
  logic taken, linkWe, misaligned, subRet, excRet, brkRet;
  logic [4:0] linkAddr;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pc_branch_unit u_pc_branch_unit (
    .clk(clk), .rstN(rstN), .instValid(instValid), .curPc(curPc),
    .instWord(instWord), .regA(regA), .regB(regB), .nextPc(nextPc),
    .taken(taken), .linkWe(linkWe), .linkAddr(linkAddr), .linkData(linkData),
    .misaligned(misaligned), .subRet(subRet), .excRet(excRet), .brkRet(brkRet)
  );

  // {pc, inst, regA, regB, expected nextPc, expected taken, expected linkWe}
  localparam int NV = 13;
  localparam logic [161:0] VEC [NV] = '{
    {32'h0000_1000, 32'h4422_0004, 32'd5, 32'd5, 32'h0000_1010, 1'b1, 1'b0},          // R2 eq hit
    {32'h0000_1000, 32'h4422_0004, 32'd5, 32'd6, 32'h0000_1004, 1'b0, 1'b0},          // R4 eq miss
    {32'h0000_2000, 32'h5C22_FFFC, 32'd1, 32'd2, 32'h0000_1FF0, 1'b1, 1'b0},          // R2 ne, negative offset
    {32'h0000_3000, 32'h4822_0010, 32'hFFFF_FFFF, 32'd1, 32'h0000_3004, 1'b0, 1'b0},  // R3 signed gt: -1 > 1 false
    {32'h0000_3000, 32'h4822_0010, 32'd2, 32'd1, 32'h0000_3040, 1'b1, 1'b0},          // R3 signed gt true
    {32'h0000_3000, 32'h5422_0010, 32'hFFFF_FFFF, 32'd1, 32'h0000_3040, 1'b1, 1'b0},  // R3 unsigned gt true
    {32'h0004_0000, 32'h4C22_8000, 32'd7, 32'd7, 32'h0002_0000, 1'b1, 1'b0},          // R2 sge equal, most negative offset
    {32'h0000_5000, 32'h5022_0008, 32'd1, 32'hFFFF_FFFF, 32'h0000_5004, 1'b0, 1'b0},  // R3 unsigned ge false
    {32'h0000_6000, 32'hE3FF_FFFF, 32'd0, 32'd0, 32'h0000_5FFC, 1'b1, 1'b0},          // R5 long offset -1
    {32'h0000_7000, 32'hF800_0100, 32'd0, 32'd0, 32'h0000_7400, 1'b1, 1'b1},          // R5 R7 imm call
    {32'h0000_9000, 32'hD860_0000, 32'h0000_8000, 32'd0, 32'h0000_8000, 1'b1, 1'b1},  // R6 R7 reg call
    {32'h0000_9000, 32'hC080_0000, 32'h0000_1234, 32'd0, 32'h0000_1234, 1'b1, 1'b0},  // R6 reg jump
    {32'h0000_A000, 32'hB400_0000, 32'd3, 32'd4, 32'h0000_A004, 1'b0, 1'b0}           // R4 non-control
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] pc, input logic [31:0] inst,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    curPc = pc; instWord = inst; regA = a; regB = b; instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 nextPc in reset", nextPc, 32'h0);
    chk("R1 flags in reset", {26'd0, taken, linkWe, misaligned, subRet, excRet, brkRet}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][161:130], VEC[i][129:98], VEC[i][97:66], VEC[i][65:34]);
      chk($sformatf("R11 R2 R4 vec%0d nextPc", i), nextPc, VEC[i][33:2]);
      chk($sformatf("R2 R4 vec%0d taken", i), {31'd0, taken}, {31'd0, VEC[i][1]});
      chk($sformatf("R7 vec%0d linkWe", i), {31'd0, linkWe}, {31'd0, VEC[i][0]});
      if (VEC[i][0]) chk($sformatf("R7 vec%0d linkData", i), linkData, VEC[i][161:130] + 32'd4);
    end
    chk("R7 linkAddr", {27'd0, linkAddr}, 32'd29);

    // R10: idle cycle holds nextPc and clears flags
    issue(32'h0000_7000, 32'hF800_0100, 32'd0, 32'd0);
    @(negedge clk);
    chk("R10 idle nextPc hold", nextPc, 32'h0000_7400);
    chk("R10 idle flags clear", {30'd0, taken, linkWe}, 32'h0);

    // R9: misaligned indirect target
    issue(32'h0000_9000, 32'hC080_0000, 32'h0000_1236, 32'd0);
    chk("R9 misaligned jump", {31'd0, misaligned}, 32'd1);
    issue(32'h0000_9000, 32'hD860_0000, 32'h0000_1231, 32'd0);
    chk("R9 misaligned call", {31'd0, misaligned}, 32'd1);
    issue(32'h0000_9000, 32'hE000_0001, 32'h0000_1233, 32'd0);
    chk("R9 no flag for imm jump", {31'd0, misaligned}, 32'd0);

    // R8: return aliases
    issue(32'h0000_B000, 32'hC3A0_0000, 32'h0000_0400, 32'd0);
    chk("R8 sub return pulses", {29'd0, subRet, excRet, brkRet}, 32'b100);
    chk("R8 sub return target", nextPc, 32'h0000_0400);
    issue(32'h0000_B000, 32'hC3C0_0000, 32'h0000_0800, 32'd0);
    chk("R8 exc return pulses", {29'd0, subRet, excRet, brkRet}, 32'b010);
    @(negedge clk);
    chk("R8 exc pulse one cycle", {29'd0, subRet, excRet, brkRet}, 32'b000);
    issue(32'h0000_B000, 32'hC3E0_0000, 32'h0000_0C00, 32'd0);
    chk("R8 brk return pulses", {29'd0, subRet, excRet, brkRet}, 32'b001);
    issue(32'h0000_B000, 32'hDBC0_0000, 32'h0000_0C00, 32'd0);
    chk("R8 call via r30 no pulse", {29'd0, subRet, excRet, brkRet}, 32'b000);

    // R1: reset mid-run
    issue(32'h0000_6000, 32'hE3FF_FFFF, 32'd0, 32'd0);
    rstN = 1'b0;
    #1;
    chk("R1 async reset nextPc", nextPc, 32'h0);
    chk("R1 async reset taken", {31'd0, taken}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule